// File: doc/BRIEF.md
# Data Memory Address Modifier

This block forms the effective data memory location (bank, row and column) for every data access of a small nibble-wide microcontroller. Two modifier registers change that location. The index register merges into direct accesses by bitwise OR. The memory pointer replaces the bank and row of register-indirect accesses. The PSW supplies the index enable bit. The pointer enable bit is stored in the modifier registers themselves.

Both modifiers live in the same three 4-bit system registers, which software reaches through a small read/write port. The upper and middle nibbles serve both views at once, so one write changes the index and the pointer together. The instruction decoder supplies the current bank, the direct operand, the indirect register contents and row field, and a flag that marks the access as indirect. The location outputs are combinational, so they can address the memory array in the same cycle.

A build parameter selects a reduced variant. In that variant the bank-carrying bits are tied to zero, so neither modifier can move an access out of bank 0.

Top module: `dmem_addr_mod`

## Requirements
- R1: After reset, all three modifier registers (window addresses 7AH upper, 7BH middle, 7CH lower) read back 0.
- R2: A write with `sr_we` high updates the addressed register at the next rising clock edge. Reads return the stored nibble. Reads of any other address return 0, and writes to any other address change nothing.
- R3: On a direct access (`acc_indirect`=0) with `psw_ixe`=0, the output bank equals `cur_bank`, the row equals `op_m[6:4]` and the column equals `op_m[3:0]`.
- R4: On a direct access with `psw_ixe`=1, the 7-bit address is `op_m` ORed with {middle[2:0], lower[3:0]}, split as row = bits 6:4 and column = bits 3:0. The bank is `cur_bank` ORed with the upper nibble.
- R5: On an indirect access with pointer enable (upper bit 3) clear, the bank is `cur_bank` and the row is `row_mr`.
- R6: On an indirect access with pointer enable set, the bank is {upper[2:0], middle[3]} and the row is middle[2:0].
- R7: On an indirect access the column always equals `reg_r`, whatever the pointer enable.
- R8: One write to the upper or middle nibble changes both the index modification and the pointer modification.
- R9: With REDUCED=1, upper[2:0] and middle[3] always read 0. The index path never alters the bank, and a pointer-enabled indirect access always yields bank 0.
- R10: The outputs follow the access inputs combinationally, within the same cycle and with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sr_we | input | 1 | System register write strobe |
| sr_addr | input | 7 | System register address |
| sr_wdata | input | 4 | System register write data |
| sr_rdata | output | 4 | System register read data |
| psw_ixe | input | 1 | Index enable bit from the PSW |
| acc_indirect | input | 1 | 1 = register-indirect access, 0 = direct |
| cur_bank | input | 4 | Current bank register |
| op_m | input | 7 | Direct operand address |
| reg_r | input | 4 | Indirect register contents (column) |
| row_mr | input | 3 | Indirect row field |
| ea_bank | output | 4 | Effective bank |
| ea_row | output | 3 | Effective row |
| ea_col | output | 4 | Effective column |

## Verification
The hardest case to reach is the alias between the two views. A value written for the index must also be seen acting as pointer enable and pointer bank, and the reverse must hold too. The stimulus writes one upper nibble with bit 3 set. It then issues a direct access and an indirect access against that one register state, and checks that the same bits appear in both results. The reduced variant is driven by the same all-ones writes next to a full instance. This shows that the tied bits stay zero on readback and that no access can leave bank 0.

// File: rtl/dam_pkg.sv
package dam_pkg;
    localparam int NIB_W  = 4;
    localparam int ROW_W  = 3;
    localparam int COL_W  = 4;
    localparam int ADDR_W = ROW_W + COL_W;
    localparam int BANK_W = 4;
    localparam int SR_AW  = 7;

    typedef struct packed {
        logic [NIB_W-1:0] hi;
        logic [NIB_W-1:0] mid;
        logic [NIB_W-1:0] lo;
    } mod_regs_t;
endpackage

// File: rtl/dam_sysregs.sv
module dam_sysregs
    import dam_pkg::*;
#(
    parameter bit               REDUCED = 1'b0,
    parameter logic [SR_AW-1:0] BASE    = 7'h7A
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_we,
    input  logic [SR_AW-1:0] sr_addr,
    input  logic [NIB_W-1:0] sr_wdata,
    output logic [NIB_W-1:0] sr_rdata,
    output mod_regs_t        regs_o
);
    localparam logic [SR_AW-1:0] A_HI  = BASE;
    localparam logic [SR_AW-1:0] A_MID = BASE + 7'd1;
    localparam logic [SR_AW-1:0] A_LO  = BASE + 7'd2;
    localparam logic [NIB_W-1:0] HI_MASK  = REDUCED ? 4'b1000 : 4'b1111;
    localparam logic [NIB_W-1:0] MID_MASK = REDUCED ? 4'b0111 : 4'b1111;

    mod_regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sr_we) begin
            case (sr_addr)
                A_HI:    st_d.hi  = sr_wdata & HI_MASK;
                A_MID:   st_d.mid = sr_wdata & MID_MASK;
                A_LO:    st_d.lo  = sr_wdata;
                default: st_d     = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (sr_addr)
            A_HI:    sr_rdata = st_q.hi;
            A_MID:   sr_rdata = st_q.mid;
            A_LO:    sr_rdata = st_q.lo;
            default: sr_rdata = '0;
        endcase
    end

    assign regs_o = st_q;

    // R2: registers hold when nothing is written
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sr_we |=> $stable(st_q));
    // R2: a write outside the window leaves the registers alone
    p_outside_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_we && sr_addr != A_HI && sr_addr != A_MID && sr_addr != A_LO) |=> $stable(st_q));
    // R9: tied bits stay zero in the reduced variant
    p_tied_r9: assert property (@(posedge clk) disable iff (!rst_n)
        REDUCED |-> (st_q.hi[2:0] == 3'd0 && st_q.mid[3] == 1'b0));
endmodule

// File: rtl/dam_direct.sv
module dam_direct
    import dam_pkg::*;
#(
    parameter bit REDUCED = 1'b0
) (
    input  logic              ixe,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ADDR_W-1:0] m_i,
    input  mod_regs_t         regs_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ADDR_W-1:0] addr_o
);
    logic [ADDR_W-1:0] idx_addr;
    logic [BANK_W-1:0] idx_bank;

    assign idx_addr = {regs_i.mid[ROW_W-1:0], regs_i.lo};

    generate
        if (REDUCED) begin : g_red
            assign idx_bank = '0;
        end else begin : g_full
            assign idx_bank = regs_i.hi;
        end
    endgenerate

    always_comb begin
        if (ixe) begin
            addr_o = m_i | idx_addr;
            bank_o = bank_i | idx_bank;
        end else begin
            addr_o = m_i;
            bank_o = bank_i;
        end
    end
endmodule

// File: rtl/dam_indirect.sv
module dam_indirect
    import dam_pkg::*;
(
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  mr_i,
    input  logic [COL_W-1:0]  r_i,
    input  mod_regs_t         regs_i,
    output logic [BANK_W-1:0] bank_o,
    output logic [ROW_W-1:0]  row_o,
    output logic [COL_W-1:0]  col_o
);
    logic mpe;
    assign mpe = regs_i.hi[NIB_W-1];

    always_comb begin
        col_o = r_i;
        if (mpe) begin
            bank_o = {regs_i.hi[2:0], regs_i.mid[NIB_W-1]};
            row_o  = regs_i.mid[ROW_W-1:0];
        end else begin
            bank_o = bank_i;
            row_o  = mr_i;
        end
    end
endmodule

// File: rtl/dmem_addr_mod.sv
module dmem_addr_mod
    import dam_pkg::*;
#(
    parameter bit               REDUCED = 1'b0,
    parameter logic [SR_AW-1:0] SR_BASE = 7'h7A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sr_we,
    input  logic [SR_AW-1:0]  sr_addr,
    input  logic [NIB_W-1:0]  sr_wdata,
    output logic [NIB_W-1:0]  sr_rdata,
    input  logic              psw_ixe,
    input  logic              acc_indirect,
    input  logic [BANK_W-1:0] cur_bank,
    input  logic [ADDR_W-1:0] op_m,
    input  logic [COL_W-1:0]  reg_r,
    input  logic [ROW_W-1:0]  row_mr,
    output logic [BANK_W-1:0] ea_bank,
    output logic [ROW_W-1:0]  ea_row,
    output logic [COL_W-1:0]  ea_col
);
    mod_regs_t         regs;
    logic [BANK_W-1:0] dir_bank, ind_bank;
    logic [ADDR_W-1:0] dir_addr;
    logic [ROW_W-1:0]  ind_row;
    logic [COL_W-1:0]  ind_col;

    dam_sysregs #(.REDUCED(REDUCED), .BASE(SR_BASE)) u_regs (
        .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_addr(sr_addr),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .regs_o(regs)
    );

    dam_direct #(.REDUCED(REDUCED)) u_dir (
        .ixe(psw_ixe), .bank_i(cur_bank), .m_i(op_m), .regs_i(regs),
        .bank_o(dir_bank), .addr_o(dir_addr)
    );

    dam_indirect u_ind (
        .bank_i(cur_bank), .mr_i(row_mr), .r_i(reg_r), .regs_i(regs),
        .bank_o(ind_bank), .row_o(ind_row), .col_o(ind_col)
    );

    always_comb begin
        if (acc_indirect) begin
            ea_bank = ind_bank;
            ea_row  = ind_row;
            ea_col  = ind_col;
        end else begin
            ea_bank = dir_bank;
            ea_row  = dir_addr[ADDR_W-1:COL_W];
            ea_col  = dir_addr[COL_W-1:0];
        end
    end

    // R3: index disabled passes the direct operand through
    p_direct_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_indirect && !psw_ixe) |-> ({ea_row, ea_col} == op_m && ea_bank == cur_bank));
    // R4: OR merge never clears an operand or bank bit
    p_or_superset_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_indirect && psw_ixe) |-> ((({ea_row, ea_col} & op_m) == op_m) && ((ea_bank & cur_bank) == cur_bank)));
    // R7: indirect column always comes from the register contents
    p_col_from_r_r7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_indirect |-> (ea_col == reg_r));
    // R9: reduced variant never leaves bank 0 on pointer access
    p_red_bank_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (REDUCED && acc_indirect && regs.hi[NIB_W-1]) |-> (ea_bank == '0));
endmodule

// File: tb/dmem_addr_mod_tb.sv
module dmem_addr_mod_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sr_we = 1'b0;
    logic [6:0] sr_addr = '0;
    logic [3:0] sr_wdata = '0;
    logic       psw_ixe = 1'b0;
    logic       acc_indirect = 1'b0;
    logic [3:0] cur_bank = '0;
    logic [6:0] op_m = '0;
    logic [3:0] reg_r = '0;
    logic [2:0] row_mr = '0;
    logic [3:0] sr_rdata, red_rdata, ea_bank, red_bank, ea_col, red_col;
    logic [2:0] ea_row, red_row;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dmem_addr_mod u_dut (
        .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .sr_rdata(sr_rdata), .psw_ixe(psw_ixe), .acc_indirect(acc_indirect),
        .cur_bank(cur_bank), .op_m(op_m), .reg_r(reg_r), .row_mr(row_mr),
        .ea_bank(ea_bank), .ea_row(ea_row), .ea_col(ea_col)
    );

    dmem_addr_mod #(.REDUCED(1'b1)) u_dut_red (
        .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_addr(sr_addr), .sr_wdata(sr_wdata),
        .sr_rdata(red_rdata), .psw_ixe(psw_ixe), .acc_indirect(acc_indirect),
        .cur_bank(cur_bank), .op_m(op_m), .reg_r(reg_r), .row_mr(row_mr),
        .ea_bank(red_bank), .ea_row(red_row), .ea_col(red_col)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [6:0] a, input logic [3:0] d);
        @(negedge clk);
        sr_we = 1'b1; sr_addr = a; sr_wdata = d;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a);
        sr_addr = a;
        #1;
    endtask

    task automatic access(input logic ind, input logic ixe, input logic [3:0] b,
                          input logic [6:0] m, input logic [3:0] r, input logic [2:0] mr);
        acc_indirect = ind; psw_ixe = ixe; cur_bank = b; op_m = m; reg_r = r; row_mr = mr;
        #1;
    endtask

    task automatic t_reset();
        rd(7'h7A); chk("R1 upper", sr_rdata, 0);
        rd(7'h7B); chk("R1 middle", sr_rdata, 0);
        rd(7'h7C); chk("R1 lower", sr_rdata, 0);
    endtask

    task automatic t_regs();
        wr(7'h7A, 4'h2); wr(7'h7B, 4'h5); wr(7'h7C, 4'h3);
        rd(7'h7A); chk("R2 upper", sr_rdata, 4'h2);
        rd(7'h7B); chk("R2 middle", sr_rdata, 4'h5);
        rd(7'h7C); chk("R2 lower", sr_rdata, 4'h3);
        wr(7'h7D, 4'hF); wr(7'h79, 4'hF);
        rd(7'h7D); chk("R2 outside read", sr_rdata, 0);
        rd(7'h7A); chk("R2 outside write upper", sr_rdata, 4'h2);
        rd(7'h7C); chk("R2 outside write lower", sr_rdata, 4'h3);
    endtask

    task automatic t_direct_off();
        access(1'b0, 1'b0, 4'h4, 7'h0C, 4'h0, 3'd0);
        chk("R3 bank", ea_bank, 4'h4);
        chk("R3 row", ea_row, 0);
        chk("R3 col", ea_col, 4'hC);
    endtask

    task automatic t_direct_on();
        // index = {101,0011} = 0x53, m = 0x0C -> 0x5F; bank 4|2 = 6
        access(1'b0, 1'b1, 4'h4, 7'h0C, 4'h0, 3'd0);
        chk("R4 bank", ea_bank, 4'h6);
        chk("R4 row", ea_row, 3'd5);
        chk("R4 col", ea_col, 4'hF);
        // R10: change inputs with no clock edge
        op_m = 7'h20; cur_bank = 4'h1; #1;
        chk("R10 row same cycle", ea_row, 3'd7);
        chk("R10 col same cycle", ea_col, 4'h3);
        chk("R10 bank same cycle", ea_bank, 4'h3);
    endtask

    task automatic t_ind_off();
        // upper = 2 -> pointer enable clear
        access(1'b1, 1'b0, 4'h9, 7'h00, 4'hA, 3'd6);
        chk("R5 bank", ea_bank, 4'h9);
        chk("R5 row", ea_row, 3'd6);
        chk("R7 col disabled", ea_col, 4'hA);
    endtask

    task automatic t_ind_on();
        wr(7'h7A, 4'hD); wr(7'h7B, 4'hA);
        access(1'b1, 1'b0, 4'h1, 7'h00, 4'h6, 3'd1);
        chk("R6 bank", ea_bank, 4'hB);
        chk("R6 row", ea_row, 3'd2);
        chk("R7 col enabled", ea_col, 4'h6);
    endtask

    task automatic t_alias();
        // same upper nibble 0xD now seen by the index path
        access(1'b0, 1'b1, 4'h0, 7'h00, 4'h0, 3'd0);
        chk("R8 index bank from shared upper", ea_bank, 4'hD);
        wr(7'h7A, 4'h0);
        access(1'b1, 1'b0, 4'h3, 7'h00, 4'h0, 3'd4);
        chk("R8 pointer disabled by write", ea_bank, 4'h3);
        chk("R8 row back to field", ea_row, 3'd4);
    endtask

    task automatic t_reduced();
        wr(7'h7A, 4'hF); wr(7'h7B, 4'hF); wr(7'h7C, 4'hF);
        rd(7'h7A); chk("R9 reduced upper read", red_rdata, 4'h8);
        rd(7'h7B); chk("R9 reduced middle read", red_rdata, 4'h7);
        access(1'b0, 1'b1, 4'h0, 7'h00, 4'h0, 3'd0);
        chk("R9 reduced index bank", red_bank, 0);
        chk("R9 reduced index row", red_row, 3'd7);
        chk("R4 full index bank all ones", ea_bank, 4'hF);
        access(1'b1, 1'b0, 4'h0, 7'h00, 4'h5, 3'd0);
        chk("R9 reduced pointer bank", red_bank, 0);
        chk("R9 reduced pointer row", red_row, 3'd7);
        chk("R6 full pointer bank all ones", ea_bank, 4'hF);
    endtask

    initial begin
        #4_000_000;
        errors++; checks++;
        $display("FAIL watchdog R1..: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_direct_off();
        t_direct_on();
        t_ind_off();
        t_ind_on();
        t_alias();
        t_reduced();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule